// File: doc/BRIEF.md
# I2C Master Command-Queue Engine

This block is a single-master I2C controller fed by a queue of 9-bit command words. Software pushes one word for each byte it wants written or read. The engine claims the bus with a START and sends the 7-bit target address together with a direction bit. It then carries out the queued commands one byte at a time. Bytes it receives go into a separate receive queue that software drains.

Both bus lines are open-drain. An output of 1 on `scl_oe` or `sda_oe` pulls the matching line low, and an output of 0 releases it. Each SCL period is four quarters, and every quarter lasts `phase_len` clock cycles.

A hold control keeps the bus claimed, with SCL low and no STOP, while software refills the command queue. When consecutive commands change direction, the engine issues a repeated START. A missing acknowledge aborts the transfer, flushes the queue and releases the bus with a STOP.

Top module: `i2c_cmdq_master`

## Requirements
- R1: A command word with bit 8 clear writes its low byte on the bus, most significant bit first. A word with bit 8 set reads one byte, and its low byte is ignored; no byte is written for it.
- R2: Each transfer opens with START, then the 7-bit target address sent MSB first, then a direction bit. The direction bit is 1 when the first queued command is a read and 0 when it is a write.
- R3: While `stop_hold` is 1 and the command queue is empty, the bus stays claimed: SCL is held low and no STOP is issued. A command pushed later continues the same transfer without a new START. Once `stop_hold` is cleared and the queue is empty, STOP follows.
- R4: If the next command's direction differs from the current one, the engine issues a repeated START and a new address phase, with no STOP in between.
- R5: A write to the target address register is accepted only while the command queue is empty and the master is idle. At any other time it is ignored.
- R6: A NACK on the address byte or on a written byte has three effects:
  - `abort` is set and stays set until `flag_clr`.
  - All pending commands are discarded.
  - STOP is issued.
- R7: The `status` bits are:
  - bit 5: master active
  - bit 4: receive queue full
  - bit 3: receive queue not empty
  - bit 2: command queue empty
  - bit 1: command queue not full
  - bit 0: overall active (master active or command queue not empty)
- R8: After each byte read, the engine sends ACK (SDA low) if the next queued command is a read. If the queue holds no further read, it sends NACK.
- R9: A byte received while the receive queue is full is discarded, and `rx_overflow` is set until `flag_clr`.
- R10: Each queue holds 16 entries. A push into a full command queue is ignored.
- R11: After reset, both lines are released, `status` is 6'b000110, and `abort` and `rx_overflow` are 0.
- R12: SCL is high for exactly 2*`phase_len` clock cycles in each bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_len | input | 16 | Clock cycles per quarter SCL period (0 is treated as 1) |
| cmd_push | input | 1 | Push `cmd_word` into the command queue |
| cmd_word | input | 9 | Bit 8: 1 = read one byte, 0 = write the low byte |
| rx_pop | input | 1 | Remove the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue |
| addr_in | input | 7 | New target address |
| addr_wr | input | 1 | Load `addr_in` into the target address register |
| stop_hold | input | 1 | Keep the bus claimed while the queue is empty |
| flag_clr | input | 1 | Clear `abort` and `rx_overflow` |
| sda_in | input | 1 | Sensed SDA line level |
| status | output | 6 | Queue and activity flags (see R7) |
| abort | output | 1 | Sticky flag: the transfer was aborted on a NACK |
| rx_overflow | output | 1 | Sticky flag: a received byte was dropped |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The bench runs a behavioural target on the wired bus through a series of command sequences:
- **Plain writes** confirm the byte order and the timing of the SCL high phase.
- **Reads whose low bytes are junk** confirm that nothing is written for a read and that the ACK/NACK pattern follows what is queued.
- **A write followed by reads** is told apart from two separate transfers by counting STARTs against STOPs.
- **A mismatched address and a NACK'd data byte** confirm the abort and the flush.
- **A held transfer** shows no STOP and an ignored address write until the hold is released.
- **A burst of 16 reads, followed by one more read**, exercises both queue limits and the overflow drop.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

    localparam int CMD_W  = 9;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int STAT_W = 6;

    localparam int ST_MACT   = 5;
    localparam int ST_RFULL  = 4;
    localparam int ST_RNEMP  = 3;
    localparam int ST_TEMPTY = 2;
    localparam int ST_TNFULL = 1;
    localparam int ST_ACT    = 0;

    typedef struct packed {
        logic              rd;
        logic [BYTE_W-1:0] data;
    } cmd_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_ADDR,
        SQ_WBYTE,
        SQ_RBYTE,
        SQ_DISPATCH,
        SQ_STOP
    } seq_state_e;

    function automatic logic is_byte_state(input seq_state_e s);
        return (s == SQ_ADDR) || (s == SQ_WBYTE) || (s == SQ_RBYTE);
    endfunction

endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/i2cq_tick.sv
module i2cq_tick #(
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_len,
    output logic               tick
);

    logic [PHASE_W-1:0] cnt;
    logic [PHASE_W-1:0] lim;

    assign lim  = (phase_len == '0) ? '0 : phase_len - PHASE_W'(1);
    assign tick = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PHASE_W'(1);
        end
    end

endmodule

// File: rtl/i2cq_sequencer.sv
module i2cq_sequencer
    import i2cq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  cmd_t              tx_head,
    input  logic              tx_empty,
    input  logic              rx_full,
    input  logic [ADDR_W-1:0] target_addr,
    input  logic              stop_hold,
    input  logic              sda_in,
    output logic              tx_pop,
    output logic              tx_flush,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              nack_evt,
    output logic              ovf_evt,
    output logic              busy,
    output logic              scl_oe,
    output logic              sda_oe
);

    seq_state_e        state;
    logic [1:0]        q;
    logic [3:0]        bitn;
    logic [BYTE_W-1:0] shreg;
    logic              dir;
    logic              ack_drv;
    logic              sampled;
    logic              ack_slot;

    assign busy     = (state != SQ_IDLE);
    assign ack_slot = (bitn == 4'd8);

    // Bus drive: quarters 1 and 2 of each bit keep SCL released (high).
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        case (state)
            SQ_IDLE: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
            SQ_START: begin
                scl_oe = (q == 2'd0) || (q == 2'd3);
                sda_oe = q[1];
            end
            SQ_STOP: begin
                scl_oe = (q == 2'd0);
                sda_oe = !q[1];
            end
            SQ_DISPATCH: begin
                scl_oe = 1'b1;
                sda_oe = 1'b0;
            end
            SQ_ADDR, SQ_WBYTE: begin
                scl_oe = (q == 2'd0) || (q == 2'd3);
                sda_oe = ack_slot ? 1'b0 : !shreg[BYTE_W-1];
            end
            SQ_RBYTE: begin
                scl_oe = (q == 2'd0) || (q == 2'd3);
                sda_oe = ack_slot ? ack_drv : 1'b0;
            end
            default: begin
                scl_oe = 1'b0;
                sda_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            q        <= '0;
            bitn     <= '0;
            shreg    <= '0;
            dir      <= 1'b0;
            ack_drv  <= 1'b0;
            sampled  <= 1'b1;
            tx_pop   <= 1'b0;
            tx_flush <= 1'b0;
            rx_push  <= 1'b0;
            rx_byte  <= '0;
            nack_evt <= 1'b0;
            ovf_evt  <= 1'b0;
        end else begin
            tx_pop   <= 1'b0;
            tx_flush <= 1'b0;
            rx_push  <= 1'b0;
            nack_evt <= 1'b0;
            ovf_evt  <= 1'b0;
            if (tick) begin
                case (state)
                    SQ_IDLE: begin
                        if (!tx_empty) begin
                            state <= SQ_START;
                            dir   <= tx_head.rd;
                            q     <= '0;
                        end
                    end
                    SQ_DISPATCH: begin
                        q <= '0;
                        if (tx_empty) begin
                            if (!stop_hold) state <= SQ_STOP;
                        end else if (tx_head.rd != dir) begin
                            state <= SQ_START;
                            dir   <= tx_head.rd;
                        end else begin
                            tx_pop <= 1'b1;
                            bitn   <= '0;
                            if (tx_head.rd) begin
                                state <= SQ_RBYTE;
                            end else begin
                                state <= SQ_WBYTE;
                                shreg <= tx_head.data;
                            end
                        end
                    end
                    SQ_START: begin
                        q <= q + 2'd1;
                        if (q == 2'd3) begin
                            state <= SQ_ADDR;
                            shreg <= {target_addr, dir};
                            bitn  <= '0;
                        end
                    end
                    SQ_STOP: begin
                        q <= q + 2'd1;
                        if (q == 2'd3) state <= SQ_IDLE;
                    end
                    default: begin
                        q <= q + 2'd1;
                        if (q == 2'd1) sampled <= sda_in;
                        if (q == 2'd3) begin
                            if (!ack_slot) begin
                                shreg <= {shreg[BYTE_W-2:0],
                                          (state == SQ_RBYTE) ? sampled : 1'b0};
                                bitn  <= bitn + 4'd1;
                                if (state == SQ_RBYTE && bitn == 4'd7) begin
                                    ack_drv <= !tx_empty && tx_head.rd;
                                end
                            end else if (state == SQ_RBYTE) begin
                                rx_byte <= shreg;
                                if (rx_full) ovf_evt <= 1'b1;
                                else         rx_push <= 1'b1;
                                state <= SQ_DISPATCH;
                            end else if (sampled) begin
                                nack_evt <= 1'b1;
                                tx_flush <= 1'b1;
                                state    <= SQ_STOP;
                                q        <= '0;
                            end else begin
                                state <= SQ_DISPATCH;
                            end
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_cmdq_master.sv
module i2c_cmdq_master
    import i2cq_pkg::*;
#(
    parameter int TXQ_DEPTH = 16,
    parameter int RXQ_DEPTH = 16,
    parameter int PHASE_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_len,
    input  logic               cmd_push,
    input  logic [CMD_W-1:0]   cmd_word,
    input  logic               rx_pop,
    output logic [BYTE_W-1:0]  rx_data,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic               addr_wr,
    input  logic               stop_hold,
    input  logic               flag_clr,
    input  logic               sda_in,
    output logic [STAT_W-1:0]  status,
    output logic               abort,
    output logic               rx_overflow,
    output logic               scl_oe,
    output logic               sda_oe
);

    logic              tick;
    cmd_t              tx_head;
    logic [CMD_W-1:0]  tx_head_raw;
    logic              tx_empty, tx_full, tx_pop, tx_flush;
    logic              rx_empty, rx_full, rx_push;
    logic [BYTE_W-1:0] rx_byte;
    logic              nack_evt, ovf_evt, busy;
    logic [ADDR_W-1:0] target_addr;

    assign tx_head = cmd_t'(tx_head_raw);

    i2cq_tick #(.PHASE_W(PHASE_W)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .phase_len (phase_len),
        .tick      (tick)
    );

    i2cq_fifo #(.WIDTH(CMD_W), .DEPTH(TXQ_DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .push  (cmd_push),
        .din   (cmd_word),
        .pop   (tx_pop),
        .flush (tx_flush),
        .dout  (tx_head_raw),
        .empty (tx_empty),
        .full  (tx_full)
    );

    i2cq_fifo #(.WIDTH(BYTE_W), .DEPTH(RXQ_DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .din   (rx_byte),
        .pop   (rx_pop),
        .flush (1'b0),
        .dout  (rx_data),
        .empty (rx_empty),
        .full  (rx_full)
    );

    i2cq_sequencer u_seq (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .tx_head     (tx_head),
        .tx_empty    (tx_empty),
        .rx_full     (rx_full),
        .target_addr (target_addr),
        .stop_hold   (stop_hold),
        .sda_in      (sda_in),
        .tx_pop      (tx_pop),
        .tx_flush    (tx_flush),
        .rx_push     (rx_push),
        .rx_byte     (rx_byte),
        .nack_evt    (nack_evt),
        .ovf_evt     (ovf_evt),
        .busy        (busy),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe)
    );

    // Address may only move while nothing is queued or in flight.
    always_ff @(posedge clk) begin
        if (rst) begin
            target_addr <= '0;
        end else if (addr_wr && tx_empty && !busy) begin
            target_addr <= addr_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            abort       <= 1'b0;
            rx_overflow <= 1'b0;
        end else begin
            if (nack_evt)      abort <= 1'b1;
            else if (flag_clr) abort <= 1'b0;
            if (ovf_evt)       rx_overflow <= 1'b1;
            else if (flag_clr) rx_overflow <= 1'b0;
        end
    end

    always_comb begin
        status            = '0;
        status[ST_MACT]   = busy;
        status[ST_RFULL]  = rx_full;
        status[ST_RNEMP]  = !rx_empty;
        status[ST_TEMPTY] = tx_empty;
        status[ST_TNFULL] = !tx_full;
        status[ST_ACT]    = busy || !tx_empty;
    end

endmodule

// File: rtl/i2cq_checker.sv
module i2cq_checker (
    input logic       clk,
    input logic       rst,
    input logic       stop_hold,
    input logic       flag_clr,
    input logic [5:0] status,
    input logic       abort,
    input logic       rx_overflow,
    input logic       scl_oe,
    input logic       sda_oe
);

    assert_idle_released_R11: assert property (@(posedge clk) disable iff (rst)
        !status[5] |-> (!scl_oe && !sda_oe));

    assert_abort_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (abort && !flag_clr) |=> abort);

    assert_abort_flushes_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(abort) |-> status[2]);

    assert_tx_flags_R7: assert property (@(posedge clk) disable iff (rst)
        status[2] |-> (status[1] && !(status[0] && !status[5])));

    assert_rx_flags_R7: assert property (@(posedge clk) disable iff (rst)
        status[4] |-> status[3]);

    assert_no_stop_in_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (stop_hold && $past(stop_hold) && !scl_oe && !$past(scl_oe)) |-> !$fell(sda_oe));

    assert_overflow_needs_data_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overflow) |-> status[3]);

endmodule

bind i2c_cmdq_master i2cq_checker u_i2cq_checker (
    .clk         (clk),
    .rst         (rst),
    .stop_hold   (stop_hold),
    .flag_clr    (flag_clr),
    .status      (status),
    .abort       (abort),
    .rx_overflow (rx_overflow),
    .scl_oe      (scl_oe),
    .sda_oe      (sda_oe)
);

// File: tb/test_i2c_cmdq_master.sv
module test_i2c_cmdq_master;

    localparam int P = 3;
    localparam logic [6:0] DEV = 7'h3A;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] phase_len = 16'(P);
    logic        cmd_push = 1'b0;
    logic [8:0]  cmd_word = '0;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_data;
    logic [6:0]  addr_in = '0;
    logic        addr_wr = 1'b0;
    logic        stop_hold = 1'b0;
    logic        flag_clr = 1'b0;
    logic [5:0]  status;
    logic        abort, rx_overflow, scl_oe, sda_oe;

    logic tgt_low = 1'b0;
    logic scl_line, sda_line;
    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || tgt_low);

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // target model state
    logic [6:0] tgt_addr = DEV;
    int   t_phase = 0;
    int   t_cnt = 0;
    logic [7:0] t_sh = '0;
    logic [7:0] t_rb = '0;
    logic t_acked = 0, t_rw = 0, t_mack = 0, t_nacked = 0;
    int   nack_at = -1;
    logic [7:0] wlog [0:31];
    logic mack_log [0:31];
    logic rwlog [0:7];
    int   wcount = 0, rcount = 0, naddr = 0, starts = 0, stops = 0;
    int   hi_run = 0, last_hi = 0;

    always #4 clk = ~clk;

    i2c_cmdq_master i_i2c_cmdq_master (
        .clk(clk), .rst(rst), .phase_len(phase_len), .cmd_push(cmd_push),
        .cmd_word(cmd_word), .rx_pop(rx_pop), .rx_data(rx_data),
        .addr_in(addr_in), .addr_wr(addr_wr), .stop_hold(stop_hold),
        .flag_clr(flag_clr), .sda_in(sda_line), .status(status),
        .abort(abort), .rx_overflow(rx_overflow), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    function automatic logic [7:0] rd_pat(input int i);
        return 8'h5C + 8'(i * 39);
    endfunction

    // ---------------- bus target model ----------------
    always @(negedge sda_line) begin
        if (scl_line) begin
            starts++;
            t_phase = 1;
            t_cnt = 0;
            tgt_low = 1'b0;
        end
    end

    always @(posedge sda_line) begin
        if (scl_line) begin
            stops++;
            t_phase = 0;
            tgt_low = 1'b0;
        end
    end

    always @(posedge scl_line) begin
        if (t_phase != 0) begin
            if (t_cnt < 8) begin
                t_sh = {t_sh[6:0], sda_line};
                t_cnt++;
            end else if (t_cnt == 8) begin
                if (t_phase == 3) begin
                    t_mack = sda_line;
                    mack_log[rcount-1] = sda_line;
                end
                t_cnt = 9;
            end
        end
    end

    always @(negedge scl_line) begin
        if (t_phase != 0) begin
            if (t_cnt == 8) begin
                if (t_phase == 1) begin
                    t_acked = (t_sh[7:1] == tgt_addr);
                    if (t_acked) begin
                        t_rw = t_sh[0];
                        rwlog[naddr] = t_sh[0];
                        naddr++;
                    end
                    tgt_low = t_acked;
                end else if (t_phase == 2) begin
                    wlog[wcount] = t_sh;
                    wcount++;
                    t_nacked = (wcount == nack_at);
                    tgt_low = !t_nacked;
                end else begin
                    tgt_low = 1'b0;
                end
            end else if (t_cnt == 9) begin
                tgt_low = 1'b0;
                t_cnt = 0;
                if (t_phase == 1)      t_phase = !t_acked ? 0 : (t_rw ? 3 : 2);
                else if (t_phase == 2) t_phase = t_nacked ? 0 : 2;
                else if (t_mack)       t_phase = 0;
                if (t_phase == 3) begin
                    t_rb = rd_pat(rcount);
                    rcount++;
                    tgt_low = !t_rb[7];
                end
            end else if (t_phase == 3 && t_cnt >= 1 && t_cnt <= 7) begin
                tgt_low = !t_rb[7-t_cnt];
            end
        end
    end

    always @(negedge clk) begin
        if (scl_line) hi_run++;
        else begin
            if (hi_run != 0) last_hi = hi_run;
            hi_run = 0;
        end
    end

    // ---------------- bench utilities ----------------
    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_log();
        wcount = 0; rcount = 0; naddr = 0; starts = 0; stops = 0; nack_at = -1;
    endtask

    task automatic push(input logic [8:0] w);
        @(negedge clk);
        cmd_push = 1'b1;
        cmd_word = w;
        @(negedge clk);
        cmd_push = 1'b0;
    endtask

    task automatic set_addr(input logic [6:0] a);
        @(negedge clk);
        addr_in = a;
        addr_wr = 1'b1;
        @(negedge clk);
        addr_wr = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        @(negedge clk);
        while (status[0] && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (4) @(negedge clk);
        chk({req, " idle reached"}, int'(n < 20000), 1);
    endtask

    task automatic pop_chk(input string req, input logic [7:0] exp);
        @(negedge clk);
        chk(req, int'(rx_data), int'(exp));
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R11 status", int'(status), 6);
        chk("R11 lines", int'({scl_oe, sda_oe}), 0);
        chk("R11 flags", int'({abort, rx_overflow}), 0);
    endtask

    task automatic t_write();
        clr_log();
        push(9'h0C3);
        push(9'h05A);
        push(9'h081);
        wait_idle("R1");
        chk("R1 write count", wcount, 3);
        chk("R1 byte0", int'(wlog[0]), 'hC3);
        chk("R1 byte1", int'(wlog[1]), 'h5A);
        chk("R1 byte2", int'(wlog[2]), 'h81);
        chk("R2 rw bit write", int'(rwlog[0]), 0);
        chk("R2 single start", starts, 1);
        chk("R6 no abort", int'(abort), 0);
        chk("R12 scl high width", last_hi, 2 * P);
    endtask

    task automatic t_read();
        clr_log();
        push(9'h1FF);
        push(9'h100);
        push(9'h1A5);
        wait_idle("R8");
        chk("R1 read writes nothing", wcount, 0);
        chk("R2 rw bit read", int'(rwlog[0]), 1);
        chk("R8 ack byte0", int'(mack_log[0]), 0);
        chk("R8 ack byte1", int'(mack_log[1]), 0);
        chk("R8 nack last", int'(mack_log[2]), 1);
        chk("R7 rx not empty", int'(status[3]), 1);
        pop_chk("R1 rx0", rd_pat(0));
        pop_chk("R1 rx1", rd_pat(1));
        pop_chk("R1 rx2", rd_pat(2));
        chk("R7 rx empty after pops", int'(status[3]), 0);
    endtask

    task automatic t_restart();
        clr_log();
        push(9'h010);
        push(9'h100);
        push(9'h100);
        wait_idle("R4");
        chk("R4 starts", starts, 2);
        chk("R4 stops", stops, 1);
        chk("R4 written", int'(wlog[0]), 'h10);
        chk("R4 second rw", int'(rwlog[1]), 1);
        pop_chk("R4 rx0", rd_pat(0));
        pop_chk("R4 rx1", rd_pat(1));
    endtask

    task automatic t_addr_nack();
        clr_log();
        set_addr(7'h21);
        push(9'h001);
        push(9'h002);
        push(9'h003);
        wait_idle("R6");
        chk("R6 abort on addr nack", int'(abort), 1);
        chk("R6 nothing written", wcount, 0);
        chk("R6 stop issued", stops, 1);
        chk("R6 queue flushed", int'(status[2]), 1);
        clear_flags();
        chk("R6 abort cleared", int'(abort), 0);
        set_addr(DEV);
    endtask

    task automatic t_data_nack();
        clr_log();
        nack_at = 2;
        push(9'h011);
        push(9'h022);
        push(9'h033);
        push(9'h044);
        wait_idle("R6");
        chk("R6 abort on data nack", int'(abort), 1);
        chk("R6 flushed after nack", wcount, 2);
        chk("R6 data stop", stops, 1);
        clear_flags();
        nack_at = -1;
    endtask

    task automatic t_hold();
        clr_log();
        @(negedge clk);
        stop_hold = 1'b1;
        push(9'h011);
        repeat (600) @(negedge clk);
        chk("R3 held active", int'(status[5]), 1);
        chk("R3 scl held low", int'(scl_oe), 1);
        chk("R3 no stop", stops, 0);
        chk("R3 first byte", wcount, 1);
        set_addr(7'h55);
        push(9'h022);
        repeat (600) @(negedge clk);
        chk("R3 no new start", starts, 1);
        chk("R3 second byte", int'(wlog[1]), 'h22);
        @(negedge clk);
        stop_hold = 1'b0;
        wait_idle("R3");
        chk("R3 stop after release", stops, 1);
        push(9'h033);
        wait_idle("R5");
        chk("R5 addr write ignored while active", int'(abort), 0);
        chk("R5 target reached", int'(wlog[2]), 'h33);
    endtask

    task automatic t_overflow();
        clr_log();
        @(negedge clk);
        cmd_word = 9'h100;
        cmd_push = 1'b1;
        repeat (17) @(negedge clk);
        cmd_push = 1'b0;
        chk("R10 tx full", int'(status[1]), 0);
        chk("R7 tx not empty", int'(status[2]), 0);
        wait_idle("R10");
        chk("R10 push when full ignored", rcount, 16);
        chk("R8 ack before last", int'(mack_log[14]), 0);
        chk("R8 nack sixteenth", int'(mack_log[15]), 1);
        chk("R7 rx full", int'(status[4]), 1);
        chk("R9 no overflow yet", int'(rx_overflow), 0);
        push(9'h100);
        wait_idle("R9");
        chk("R9 overflow set", int'(rx_overflow), 1);
        for (int i = 0; i < 16; i++) pop_chk("R9 kept bytes", rd_pat(i));
        chk("R9 dropped byte absent", int'(status[3]), 0);
        clear_flags();
        chk("R9 overflow cleared", int'(rx_overflow), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        set_addr(DEV);
        t_write();
        t_read();
        t_restart();
        t_addr_nack();
        t_data_nack();
        t_hold();
        t_overflow();
        finish_run();
    end

endmodule